// File: doc/BRIEF.md
# FPGA Configuration Handshake Controller

This block is the device-side sequencer that walks a programmable device from power-up through configuration and into user mode, against an external host. It holds the host's active-low configuration request, drives an active-low status line back to the host, and raises a configuration-complete flag and then an initialisation-complete flag. Bitstream reception, device cleaning and initialisation are handled by other logic. That logic is reached through single-cycle start pulses and single-cycle done or error pulses. A user-mode enable output stands in for releasing the I/O from high impedance.

A mode-select input chooses the configuration interface. It is captured once, in the first clock after reset, and held until the next reset. When the host pulls the request low while a configuration is in progress or finished, the block runs a cleaning phase. It then drops status low to acknowledge, and waits for the request to go high again. A failed configuration is reported as a status-low pulse of one millisecond. Its length comes from a clock-frequency parameter. After the pulse the block waits for the host to cycle the request before it tries again.

Top module: `cfg_seq_ctrl`

## Requirements
- R1: While reset is held and in the first cycle after it, status, conf-done, init-done, user-enable and all three start pulses are low.
- R2: cfg_if_sel takes the value of mode_sel in the first clock after reset, and holds it whatever mode_sel does until the next reset.
- R3: While idle with the synchronised request low, status stays low and cfg_start never pulses.
- R4: With the request high in idle, cfg_start pulses for exactly one cycle and status goes high for the configuration phase.
- R5: cfg_ok during configuration raises conf-done and gives one init_start pulse. A following init_done_in raises init-done and user-enable.
- R6: init-done is never high without conf-done, and user-enable always equals init-done.
- R7: The request going low during configuration, initialisation or user mode clears conf-done, init-done and user-enable and gives one clean_start pulse. Status stays high until clean_done, then goes low.
- R8: After cleaning, the request high again starts a new configuration, with one cfg_start pulse and status high.
- R9: cfg_err during configuration drives status low for exactly CLK_HZ/1000 cycles, after which status returns high.
- R10: conf-done stays low throughout a failed attempt and its error pulse.
- R11: After an error, no configuration starts while the request stays high. Only a low then a high level on the request starts the next one.
- R12: When cfg_ok and cfg_err arrive in the same cycle, the error wins: the status pulse follows and conf-done stays low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| mode_sel | input | MODE_W | Configuration interface select, captured after reset |
| ncfg_req | input | 1 | Host configuration request, active low, asynchronous |
| cfg_ok | input | 1 | Pulse: bitstream received correctly |
| cfg_err | input | 1 | Pulse: bitstream reception failed |
| clean_done | input | 1 | Pulse: device cleaning finished |
| init_done_in | input | 1 | Pulse: initialisation finished |
| cfg_if_sel | output | MODE_W | Captured interface select |
| nstat_o | output | 1 | Status to host, active low |
| conf_done_o | output | 1 | Configuration complete |
| init_done_o | output | 1 | Initialisation complete |
| user_en_o | output | 1 | User mode, I/O released |
| cfg_start | output | 1 | Pulse: begin bitstream reception |
| clean_start | output | 1 | Pulse: begin device cleaning |
| init_start | output | 1 | Pulse: begin initialisation |

## Verification
Random sequences mix four scenarios. In a clean run to user mode followed by a teardown, the three start pulses must each appear once. An abort during configuration or initialisation must reach cleaning from any busy phase. An error, sometimes with cfg_ok in the same cycle, tests error priority and the exact pulse length. Directed cases hold the request high after an error to show no restart, change mode_sel throughout to show the captured select does not move, and apply a second reset with a new mode to show it is captured again.

// File: rtl/cfg_seq_pkg.sv
// Package: shared state encoding of the configuration handshake controller.
// Assumes: a single controller instance uses these types and its checker.
package cfg_seq_pkg;
    typedef enum logic [2:0] {
        ST_BOOT      = 3'd0,
        ST_IDLE      = 3'd1,
        ST_CONFIG    = 3'd2,
        ST_INIT      = 3'd3,
        ST_USER      = 3'd4,
        ST_CLEAN     = 3'd5,
        ST_ERR_PULSE = 3'd6,
        ST_ERR_HOLD  = 3'd7
    } seq_state_t;
endpackage

// File: rtl/cfg_sync.sv
// Module: cfg_sync
// Brings an asynchronous level into the clock domain through STAGES flops.
// Assumes: STAGES >= 2; the reset value is low, which reads as a held request.
module cfg_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic d_async,
    output logic q_sync
);
    logic [STAGES-1:0] chain;

    genvar g;
    generate
        for (g = 0; g < STAGES; g++) begin : g_stage
            // One synchroniser stage: stage 0 samples the pin, later stages follow.
            always_ff @(posedge clk) begin
                if (!rst_n)      chain[g] <= 1'b0;
                else if (g == 0) chain[g] <= d_async;
                else             chain[g] <= chain[(g == 0) ? 0 : g-1];
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/cfg_pulse_timer.sv
// Module: cfg_pulse_timer
// Down-counter that times the error status pulse. A load sets it to
// CYCLES-1; expired is high once it reaches zero.
// Assumes: CYCLES >= 1; the load is a single-cycle strobe.
module cfg_pulse_timer #(
    parameter int CYCLES = 1000
) (
    input  logic clk,
    input  logic rst_n,
    input  logic load,
    output logic expired
);
    localparam int CNT_W = $clog2(CYCLES + 1);

    logic [CNT_W-1:0] cnt;

    // Count down from the load value to zero and stop there.
    always_ff @(posedge clk) begin
        if (!rst_n)          cnt <= '0;
        else if (load)       cnt <= CNT_W'(CYCLES - 1);
        else if (cnt != '0)  cnt <= cnt - 1'b1;
    end

    assign expired = (cnt == '0);
endmodule

// File: rtl/cfg_seq_fsm.sv
// Module: cfg_seq_fsm
// Sequencing state machine: boot, idle, configure, initialise, user mode,
// clean, and the error pulse and hold. Start pulses are registered and appear
// in the first cycle of the phase they start.
// Assumes: req_s is synchronised; handshake inputs are single-cycle pulses.
module cfg_seq_fsm
    import cfg_seq_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       req_s,
    input  logic       cfg_ok,
    input  logic       cfg_err,
    input  logic       clean_done,
    input  logic       init_done_in,
    input  logic       tmr_expired,
    output logic       tmr_load,
    output seq_state_t state,
    output logic       cfg_start,
    output logic       clean_start,
    output logic       init_start
);
    seq_state_t nxt;

    // Next-state selection; a host request low outranks the handshake inputs,
    // and an error outranks a success.
    always_comb begin
        nxt = state;
        unique case (state)
            ST_BOOT:      nxt = ST_IDLE;
            ST_IDLE:      if (req_s) nxt = ST_CONFIG;
            ST_CONFIG: begin
                if (!req_s)       nxt = ST_CLEAN;
                else if (cfg_err) nxt = ST_ERR_PULSE;
                else if (cfg_ok)  nxt = ST_INIT;
            end
            ST_INIT: begin
                if (!req_s)            nxt = ST_CLEAN;
                else if (init_done_in) nxt = ST_USER;
            end
            ST_USER:      if (!req_s) nxt = ST_CLEAN;
            ST_CLEAN:     if (clean_done) nxt = ST_IDLE;
            ST_ERR_PULSE: if (tmr_expired) nxt = ST_ERR_HOLD;
            ST_ERR_HOLD:  if (!req_s) nxt = ST_IDLE;
            default:      nxt = ST_BOOT;
        endcase
    end

    assign tmr_load = (state == ST_CONFIG) && (nxt == ST_ERR_PULSE);

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_BOOT;
        else        state <= nxt;
    end

    // Start strobes, one cycle, on entry to their phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cfg_start   <= 1'b0;
            clean_start <= 1'b0;
            init_start  <= 1'b0;
        end else begin
            cfg_start   <= (nxt == ST_CONFIG) && (state != ST_CONFIG);
            clean_start <= (nxt == ST_CLEAN)  && (state != ST_CLEAN);
            init_start  <= (nxt == ST_INIT)   && (state != ST_INIT);
        end
    end
endmodule

// File: rtl/cfg_seq_ctrl.sv
// Module: cfg_seq_ctrl (top)
// Device-side configuration handshake controller. Synchronises the host
// request, runs the sequencer, captures the interface select once after
// reset and decodes the host-facing flags from the sequencer state.
// Assumes: CLK_HZ >= 1000 for a meaningful 1 ms pulse; reset is synchronous.
module cfg_seq_ctrl
    import cfg_seq_pkg::*;
#(
    parameter int CLK_HZ      = 100_000_000,
    parameter int MODE_W      = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [MODE_W-1:0] mode_sel,
    input  logic              ncfg_req,
    input  logic              cfg_ok,
    input  logic              cfg_err,
    input  logic              clean_done,
    input  logic              init_done_in,
    output logic [MODE_W-1:0] cfg_if_sel,
    output logic              nstat_o,
    output logic              conf_done_o,
    output logic              init_done_o,
    output logic              user_en_o,
    output logic              cfg_start,
    output logic              clean_start,
    output logic              init_start
);
    localparam int PULSE_CYC = (CLK_HZ / 1000 < 1) ? 1 : CLK_HZ / 1000;

    logic       req_s;
    logic       tmr_load;
    logic       tmr_expired;
    seq_state_t state;
    logic [MODE_W-1:0] mode_q;

    cfg_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .d_async (ncfg_req),
        .q_sync  (req_s)
    );

    cfg_pulse_timer #(.CYCLES(PULSE_CYC)) u_tmr (
        .clk     (clk),
        .rst_n   (rst_n),
        .load    (tmr_load),
        .expired (tmr_expired)
    );

    cfg_seq_fsm u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_s        (req_s),
        .cfg_ok       (cfg_ok),
        .cfg_err      (cfg_err),
        .clean_done   (clean_done),
        .init_done_in (init_done_in),
        .tmr_expired  (tmr_expired),
        .tmr_load     (tmr_load),
        .state        (state),
        .cfg_start    (cfg_start),
        .clean_start  (clean_start),
        .init_start   (init_start)
    );

    // Capture the interface select only in the boot cycle after reset.
    always_ff @(posedge clk) begin
        if (!rst_n)                mode_q <= '0;
        else if (state == ST_BOOT) mode_q <= mode_sel;
    end

    // Host-facing flags decoded from the sequencer state.
    always_comb begin
        nstat_o     = (state == ST_CONFIG) || (state == ST_INIT) ||
                      (state == ST_USER)   || (state == ST_CLEAN) ||
                      (state == ST_ERR_HOLD);
        conf_done_o = (state == ST_INIT) || (state == ST_USER);
        init_done_o = (state == ST_USER);
        user_en_o   = (state == ST_USER);
    end

    assign cfg_if_sel = mode_q;
endmodule

// File: rtl/cfg_seq_chk.sv
// Module: cfg_seq_chk
// Property checker for cfg_seq_ctrl, attached by the bind below.
// Assumes: connected to the top's ports and its state and synchronised request.
module cfg_seq_chk
    import cfg_seq_pkg::*;
#(
    parameter int MODE_W = 3
) (
    input logic              clk,
    input logic              rst_n,
    input seq_state_t        state,
    input logic              req_s,
    input logic              cfg_err,
    input logic [MODE_W-1:0] cfg_if_sel,
    input logic              nstat_o,
    input logic              conf_done_o,
    input logic              init_done_o,
    input logic              user_en_o,
    input logic              cfg_start,
    input logic              clean_start,
    input logic              init_start
);
    AST_INIT_NEEDS_CONF: assert property (@(posedge clk) disable iff (!rst_n)
        init_done_o |-> conf_done_o); // R6
    AST_USER_TRACKS_INIT: assert property (@(posedge clk) disable iff (!rst_n)
        user_en_o == init_done_o); // R6
    AST_MODE_FROZEN: assert property (@(posedge clk) disable iff (!rst_n)
        state != ST_BOOT |=> $stable(cfg_if_sel)); // R2
    AST_CFG_START_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_start |=> !cfg_start); // R4
    AST_ERR_STATUS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_CONFIG && req_s && cfg_err) |=> !nstat_o && !conf_done_o); // R9
    AST_ERR_NO_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        (state == ST_ERR_PULSE || state == ST_ERR_HOLD) |-> !conf_done_o); // R10
    AST_CLEAN_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        clean_start |-> nstat_o && !conf_done_o && !user_en_o); // R7
    AST_START_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({cfg_start, clean_start, init_start})); // R4
endmodule

bind cfg_seq_ctrl cfg_seq_chk #(.MODE_W(MODE_W)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .state       (state),
    .req_s       (req_s),
    .cfg_err     (cfg_err),
    .cfg_if_sel  (cfg_if_sel),
    .nstat_o     (nstat_o),
    .conf_done_o (conf_done_o),
    .init_done_o (init_done_o),
    .user_en_o   (user_en_o),
    .cfg_start   (cfg_start),
    .clean_start (clean_start),
    .init_start  (init_start)
);

// File: tb/tb_cfg_seq_ctrl.sv
// Bench for cfg_seq_ctrl: seeded random scenario mix plus directed corners.
module tb_cfg_seq_ctrl;
    localparam int CLK_HZ = 20_000;
    localparam int PULSE  = CLK_HZ / 1000;
    localparam int MW     = 3;

    typedef enum int {P_IDLE, P_CONFIG, P_INIT, P_USER, P_CLEAN, P_HOLD} phase_t;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic [MW-1:0] mode_sel = '0;
    logic          ncfg_req = 1'b0;
    logic          cfg_ok = 1'b0, cfg_err = 1'b0, clean_done = 1'b0, init_done_in = 1'b0;
    logic [MW-1:0] cfg_if_sel;
    logic          nstat_o, conf_done_o, init_done_o, user_en_o;
    logic          cfg_start, clean_start, init_start;

    int n_chk = 0, n_fail = 0, cycles = 0;
    int cnt_cs = 0, cnt_cls = 0, cnt_is = 0;
    logic [MW-1:0] exp_mode;
    bit finished = 0;

    cfg_seq_ctrl #(.CLK_HZ(CLK_HZ), .MODE_W(MW)) dut (
        .clk(clk), .rst_n(rst_n), .mode_sel(mode_sel), .ncfg_req(ncfg_req),
        .cfg_ok(cfg_ok), .cfg_err(cfg_err), .clean_done(clean_done),
        .init_done_in(init_done_in), .cfg_if_sel(cfg_if_sel), .nstat_o(nstat_o),
        .conf_done_o(conf_done_o), .init_done_o(init_done_o), .user_en_o(user_en_o),
        .cfg_start(cfg_start), .clean_start(clean_start), .init_start(init_start)
    );

    always #2 clk = ~clk;

    // Expected {status, conf-done, init-done, user-enable} for each phase.
    function automatic logic [3:0] exp_flags(phase_t p);
        case (p)
            P_IDLE:  return 4'b0000;
            P_INIT:  return 4'b1100;
            P_USER:  return 4'b1111;
            default: return 4'b1000;
        endcase
    endfunction

    task automatic chk(input bit ok, input string req, input string what,
                       input int act, input int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic chk_phase(input phase_t p, input string req);
        logic [3:0] act;
        act = {nstat_o, conf_done_o, init_done_o, user_en_o};
        chk(act == exp_flags(p), req, "flags", int'(act), int'(exp_flags(p)));
    endtask

    task automatic clr();
        cnt_cs = 0; cnt_cls = 0; cnt_is = 0;
    endtask

    task automatic step(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk);
            cnt_cs  += int'(cfg_start);
            cnt_cls += int'(clean_start);
            cnt_is  += int'(init_start);
        end
    endtask

    task automatic set_req(input logic v);
        clr();
        ncfg_req = v;
        step(6);
    endtask

    // which: 0 cfg_ok, 1 cfg_err, 2 both, 3 clean_done, 4 init_done_in
    task automatic pulse_in(input int which);
        clr();
        cfg_ok       = (which == 0 || which == 2);
        cfg_err      = (which == 1 || which == 2);
        clean_done   = (which == 3);
        init_done_in = (which == 4);
        step(1);
        cfg_ok = 0; cfg_err = 0; clean_done = 0; init_done_in = 0;
    endtask

    task automatic chk_mode(input string req);
        chk(cfg_if_sel == exp_mode, req, "cfg_if_sel", int'(cfg_if_sel), int'(exp_mode));
    endtask

    task automatic do_reset(input logic [MW-1:0] m);
        rst_n = 0; mode_sel = m; ncfg_req = 0;
        step(3);
        chk_phase(P_IDLE, "R1");
        chk({cfg_start, clean_start, init_start} == 3'b000, "R1", "starts in reset",
            int'({cfg_start, clean_start, init_start}), 0);
        rst_n = 1;
        step(1);
        chk_phase(P_IDLE, "R1");
        exp_mode = m;
        mode_sel = m + 1'b1;
        step(1);
        chk_mode("R2");
    endtask

    // From idle with the request low, configure up to the given phase.
    task automatic go_to(input phase_t target);
        set_req(1);
        chk_phase(P_CONFIG, "R4");
        chk(cnt_cs == 1, "R4", "cfg_start pulses", cnt_cs, 1);
        if (target == P_CONFIG) return;
        pulse_in(0);
        step(2);
        chk_phase(P_INIT, "R5");
        chk(cnt_is == 1, "R5", "init_start pulses", cnt_is, 1);
        if (target == P_INIT) return;
        pulse_in(4);
        step(1);
        chk_phase(P_USER, "R5");
        chk(init_done_o && user_en_o && conf_done_o, "R6", "user flags", int'(user_en_o), 1);
    endtask

    task automatic teardown();
        set_req(0);
        chk_phase(P_CLEAN, "R7");
        chk(cnt_cls == 1, "R7", "clean_start pulses", cnt_cls, 1);
        step(1 + int'($urandom % 5));
        chk_phase(P_CLEAN, "R7");
        pulse_in(3);
        step(1);
        chk_phase(P_IDLE, "R7");
    endtask

    task automatic error_case(input bit both);
        int lows;
        go_to(P_CONFIG);
        pulse_in(both ? 2 : 1);
        lows = 0;
        while (!nstat_o && lows < 1000) begin
            chk(!conf_done_o, both ? "R12" : "R10", "conf_done in pulse", int'(conf_done_o), 0);
            lows++;
            step(1);
        end
        chk(lows == PULSE, "R9", "status low cycles", lows, PULSE);
        chk_phase(P_HOLD, both ? "R12" : "R9");
        clr();
        step(5 + int'($urandom % 10));
        chk(cnt_cs == 0, "R11", "no restart while high", cnt_cs, 0);
        chk_phase(P_HOLD, "R11");
        set_req(0);
        chk_phase(P_IDLE, "R11");
        set_req(1);
        chk(cnt_cs == 1, "R11", "restart after low-high", cnt_cs, 1);
        chk_phase(P_CONFIG, "R11");
        teardown();
    endtask

    // Watchdog: a hung run counts as a failure and still prints the summary.
    initial begin
        forever begin
            @(posedge clk);
            cycles++;
            if (cycles > 150_000 && !finished) begin
                n_fail++;
                $display("FAIL watchdog actual=%0d expected=%0d", cycles, 150_000);
                $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
                $finish;
            end
        end
    end

    initial begin
        void'($urandom(32'd4711));
        do_reset(3'd5);

        // R3: idle holds with the request low
        clr();
        step(10);
        chk(cnt_cs == 0, "R3", "cfg_start in idle", cnt_cs, 0);
        chk_phase(P_IDLE, "R3");

        // Directed: full run, teardown, R8 restart, directed error corners
        go_to(P_USER);
        teardown();
        go_to(P_CONFIG);
        chk(cnt_cs == 1, "R8", "restart after clean", cnt_cs, 1);
        teardown();
        error_case(0);
        error_case(1);

        for (int it = 0; it < 40; it++) begin
            mode_sel = MW'($urandom);
            case ($urandom % 4)
                0: go_to(P_USER);
                1: go_to(P_CONFIG);
                2: go_to(P_INIT);
                default: ;
            endcase
            if (conf_done_o || nstat_o) teardown();
            else error_case(1'($urandom));
            chk_mode("R2");
        end

        do_reset(3'd2);
        go_to(P_USER);
        chk_mode("R2");

        finished = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule